// File: doc/BRIEF.md
# Register-Fetch Interlock for a Six-Stage Pipeline

This block decides, every cycle, whether the instruction in the register-fetch stage of a single-issue, in-order, six-stage integer pipeline may proceed. The pipeline stages are fetch, decode, register fetch, execute, memory and writeback. There are no forwarding paths. The register file is written early in the writeback cycle and read late in the register-fetch cycle. A consumer can therefore read its operand in the same cycle that its producer reaches writeback, but not earlier.

The block compares the used source registers of the register-fetch instruction with the destinations of the valid, writing instructions in execute and memory. On a match it raises a hold for the fetch, decode and register-fetch stage registers. In the same cycle it asks the execute stage to load a bubble. The decision is purely combinational. Results from ALU operations and from loads both become visible only at writeback, so the interlock treats them alike. A store's data register is just another used source.

Top module: `rf_interlock`

## Requirements
- R1: When the register-fetch instruction is valid and uses a nonzero source (A or B) equal to the destination of a valid, writing instruction in execute, `hold_front` is 1 in that same cycle.
- R2: The same rule applies to a valid, writing instruction in the memory stage.
- R3: A consumer directly behind its producer incurs exactly 2 hold cycles. With one unrelated instruction between them it incurs 1 hold cycle. With two or more between them it incurs 0, because a producer in writeback never stalls.
- R4: Register number 0 never causes a hold, whether it appears as the consumer's source or as the producer's destination.
- R5: A source whose use flag is 0 never causes a hold, whatever its register number.
- R6: A producer with its valid bit at 0 (a bubble) or its write enable at 0 never causes a hold.
- R7: `ex_bubble` equals `hold_front` in every cycle. While held, a bubble (valid = 0) enters execute each cycle.
- R8: When the register-fetch stage holds no valid instruction (`rf_vld` = 0), `hold_front` is 0.
- R9: A store whose data register (source B) matches a pending destination is held exactly as an ALU source would be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_vld | input | 1 | Register-fetch stage holds a valid instruction |
| rf_src_a | input | REG_W | First source register number |
| rf_use_a | input | 1 | First source is read |
| rf_src_b | input | REG_W | Second source register number (store data for stores) |
| rf_use_b | input | 1 | Second source is read |
| ex_vld | input | 1 | Execute stage holds a valid instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Execute instruction destination |
| mem_vld | input | 1 | Memory stage holds a valid instruction |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_dst | input | REG_W | Memory instruction destination |
| hold_front | output | 1 | Hold fetch, decode and register-fetch stage registers |
| ex_bubble | output | 1 | Load a bubble into execute |

## Verification
Hazards against execute and against memory can be present in the same cycle. The two sources can also match two different producers at once. The vector table sets up both collisions: source A against execute and source B against memory, and one source matching both stages. The expected result in each case is a single hold. The bench also runs short programs through a model of the stage registers kept in the bench. It counts the hold cycles seen by each consumer, and those counts are judged against the 2/1/0 stall distances.

// File: rtl/rf_interlock.sv
module rf_interlock #(
  parameter int REG_W = 5
) (
  input  logic             rf_vld,
  input  logic [REG_W-1:0] rf_src_a,
  input  logic             rf_use_a,
  input  logic [REG_W-1:0] rf_src_b,
  input  logic             rf_use_b,
  input  logic             ex_vld,
  input  logic             ex_we,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_vld,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_dst,
  output logic             hold_front,
  output logic             ex_bubble
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_live, mem_live;
  logic a_live, b_live;
  logic a_ex, b_ex, a_mem, b_mem;

  assign ex_live  = ex_vld  & ex_we  & (ex_dst  != ZERO_REG);
  assign mem_live = mem_vld & mem_we & (mem_dst != ZERO_REG);
  assign a_live   = rf_use_a & (rf_src_a != ZERO_REG);
  assign b_live   = rf_use_b & (rf_src_b != ZERO_REG);

  assign a_ex  = a_live & ex_live  & (rf_src_a == ex_dst);
  assign b_ex  = b_live & ex_live  & (rf_src_b == ex_dst);
  assign a_mem = a_live & mem_live & (rf_src_a == mem_dst);
  assign b_mem = b_live & mem_live & (rf_src_b == mem_dst);

  assign hold_front = rf_vld & (a_ex | b_ex | a_mem | b_mem);
  assign ex_bubble  = hold_front;

endmodule

module rf_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             rf_vld,
  input logic [REG_W-1:0] rf_src_a,
  input logic             rf_use_a,
  input logic [REG_W-1:0] rf_src_b,
  input logic             rf_use_b,
  input logic             ex_vld,
  input logic             ex_we,
  input logic [REG_W-1:0] ex_dst,
  input logic             mem_vld,
  input logic             mem_we,
  input logic [REG_W-1:0] mem_dst,
  input logic             hold_front,
  input logic             ex_bubble
);

  logic known;
  assign known = !$isunknown({rf_vld, rf_src_a, rf_use_a, rf_src_b, rf_use_b,
                              ex_vld, ex_we, ex_dst, mem_vld, mem_we, mem_dst,
                              hold_front, ex_bubble});

  always_comb begin
    if (known) begin
      if (rf_vld && ex_vld && ex_we && rf_use_a && rf_src_a != 0 && rf_src_a == ex_dst)
        assert_ex_match_holds_R1: assert (hold_front) else $error("ex hazard missed");
      if (rf_vld && mem_vld && mem_we && rf_use_b && rf_src_b != 0 && rf_src_b == mem_dst)
        assert_mem_match_holds_R2: assert (hold_front) else $error("mem hazard missed");
      if ((rf_src_a == 0 || !rf_use_a) && (rf_src_b == 0 || !rf_use_b))
        assert_zero_or_unused_quiet_R4: assert (!hold_front) else $error("false hold");
      if ((!ex_vld || !ex_we) && (!mem_vld || !mem_we))
        assert_no_writer_quiet_R6: assert (!hold_front) else $error("hold without writer");
      if (!rf_vld)
        assert_idle_rf_quiet_R8: assert (!hold_front) else $error("hold on empty stage");
      assert_bubble_with_hold_R7: assert (ex_bubble == hold_front) else $error("bubble mismatch");
    end
  end

endmodule

bind rf_interlock rf_interlock_chk #(.REG_W(REG_W)) chk (.*);

// File: tb/rf_interlock_test.sv
module rf_interlock_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       v;
    logic [4:0] d;
    logic       we;
    logic [4:0] a;
    logic       ua;
    logic [4:0] b;
    logic       ub;
  } ins_t;

  int n_chk = 0, n_fail = 0;
  logic vec_mode = 1'b1;
  logic run = 1'b0;

  logic       v_rv, v_ua, v_ub, v_ev, v_ew, v_mv, v_mw;
  logic [4:0] v_sa, v_sb, v_ed, v_md;

  ins_t prog [8];
  ins_t rf_s, ex_s, m_s;
  int pc;

  logic       rf_vld, rf_use_a, rf_use_b, ex_vld, ex_we, mem_vld, mem_we;
  logic [4:0] rf_src_a, rf_src_b, ex_dst, mem_dst;
  logic       hold_front, ex_bubble;

  assign rf_vld   = vec_mode ? v_rv : rf_s.v;
  assign rf_src_a = vec_mode ? v_sa : rf_s.a;
  assign rf_use_a = vec_mode ? v_ua : rf_s.ua;
  assign rf_src_b = vec_mode ? v_sb : rf_s.b;
  assign rf_use_b = vec_mode ? v_ub : rf_s.ub;
  assign ex_vld   = vec_mode ? v_ev : ex_s.v;
  assign ex_we    = vec_mode ? v_ew : ex_s.we;
  assign ex_dst   = vec_mode ? v_ed : ex_s.d;
  assign mem_vld  = vec_mode ? v_mv : m_s.v;
  assign mem_we   = vec_mode ? v_mw : m_s.we;
  assign mem_dst  = vec_mode ? v_md : m_s.d;

  rf_interlock #(.REG_W(5)) uut (.*);

  always @(posedge clk) begin
    if (!run) begin
      rf_s <= '0; ex_s <= '0; m_s <= '0; pc <= 0;
    end else begin
      m_s  <= ex_s;
      ex_s <= hold_front ? '0 : rf_s;
      if (!hold_front) begin
        rf_s <= (pc < 8) ? prog[pc] : '0;
        pc   <= pc + 1;
      end
    end
  end

  // tag[31:28] rv sa ua sb ub ev ew ed mv mw md exp
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b1},  // R1 A vs EX
    {4'd1, 1'b1, 5'd0, 1'b0, 5'd9, 1'b1, 1'b1, 1'b1, 5'd9, 1'b0, 1'b0, 5'd0, 1'b1},  // R1 B vs EX
    {4'd2, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b1},  // R2 A vs M
    {4'd2, 1'b1, 5'd3, 1'b1, 5'd8, 1'b1, 1'b1, 1'b1, 5'd3, 1'b1, 1'b1, 5'd8, 1'b1},  // R2 A-EX and B-M together
    {4'd2, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1},  // R2 one source hits both
    {4'd1, 1'b1, 5'd5, 1'b1, 5'd6, 1'b1, 1'b1, 1'b1, 5'd7, 1'b1, 1'b1, 5'd8, 1'b0},  // R1 no match
    {4'd4, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0},  // R4 r0 both sides
    {4'd5, 1'b1, 5'd3, 1'b0, 5'd3, 1'b0, 1'b1, 1'b1, 5'd3, 1'b1, 1'b1, 5'd3, 1'b0},  // R5 unused sources
    {4'd5, 1'b1, 5'd3, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b0},  // R5 only unused A matches
    {4'd6, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 1'b1, 5'd3, 1'b0},  // R6 invalid producers
    {4'd6, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 5'd3, 1'b1, 1'b0, 5'd3, 1'b0},  // R6 non-writing producers
    {4'd8, 1'b0, 5'd3, 1'b1, 5'd3, 1'b1, 1'b1, 1'b1, 5'd3, 1'b1, 1'b1, 5'd3, 1'b0},  // R8 empty RF
    {4'd9, 1'b1, 5'd2, 1'b1, 5'd11, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd11, 1'b1}, // R9 store data vs M
    {4'd7, 1'b1, 5'd31, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'd31, 1'b0, 1'b0, 5'd0, 1'b1}, // R7 top register
    {4'd7, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0}   // R7 all idle
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic run_seq(input string tag, input int gap, input ins_t prod,
                         input ins_t cons, input int exp);
    int cnt = 0;
    int bub_bad = 0;
    for (int i = 0; i < 8; i++) prog[i] = '0;
    prog[0] = prod;
    for (int i = 1; i <= gap; i++) prog[i] = '{v:1'b1, default:'0};
    prog[gap + 1] = cons;
    @(negedge clk) run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (14) begin
      @(negedge clk);
      if (hold_front) cnt++;
      if (ex_bubble !== hold_front) bub_bad++;
    end
    run = 1'b0;
    n_chk++;
    if (cnt != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d stalls expected %0d", tag, cnt, exp);
    end
    check({tag, " R7 bubble"}, bub_bad == 0, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ins_t alu_w7, use_a7, use_b7, store7, w0, use0;
    {v_rv, v_sa, v_ua, v_sb, v_ub, v_ev, v_ew, v_ed, v_mv, v_mw, v_md} = '0;
    repeat (2) @(negedge clk);
    check("R8 idle state", hold_front, 1'b0);
    check("R7 idle bubble", ex_bubble, 1'b0);

    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      {v_rv, v_sa, v_ua, v_sb, v_ub, v_ev, v_ew, v_ed, v_mv, v_mw, v_md} = VEC[k][27:1];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[k][31:28], k), hold_front, VEC[k][0]);
      check($sformatf("R7 vector %0d bubble", k), ex_bubble, VEC[k][0]);
    end

    vec_mode = 1'b0;
    alu_w7 = '{v:1'b1, d:5'd7, we:1'b1, a:5'd1, ua:1'b1, b:5'd2, ub:1'b1};
    use_a7 = '{v:1'b1, d:5'd4, we:1'b1, a:5'd7, ua:1'b1, b:5'd5, ub:1'b1};
    use_b7 = '{v:1'b1, d:5'd4, we:1'b1, a:5'd5, ua:1'b1, b:5'd7, ub:1'b1};
    store7 = '{v:1'b1, d:5'd0, we:1'b0, a:5'd8, ua:1'b1, b:5'd7, ub:1'b1};
    w0     = '{v:1'b1, d:5'd0, we:1'b1, a:5'd1, ua:1'b1, b:5'd0, ub:1'b0};
    use0   = '{v:1'b1, d:5'd4, we:1'b1, a:5'd0, ua:1'b1, b:5'd0, ub:1'b1};

    run_seq("R3 back-to-back", 0, alu_w7, use_a7, 2);
    run_seq("R3 gap one", 1, alu_w7, use_a7, 1);
    run_seq("R3 gap two", 2, alu_w7, use_a7, 0);
    run_seq("R3 gap three", 3, alu_w7, use_b7, 0);
    run_seq("R9 store data back-to-back", 0, alu_w7, store7, 2);
    run_seq("R9 store data gap one", 1, alu_w7, store7, 1);
    run_seq("R4 r0 producer and consumer", 0, w0, use0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule